// File: doc/BRIEF.md
# Split-Access 64-bit Time Counter

This block holds a 64-bit counter that advances by one on every cycle in which a tick-enable input is high. Software reaches it through a special-register port made of a register number, separate read and write strobes, a privilege flag, 32-bit write data and 32-bit read data. Each 32-bit half of the counter is reached at its own register numbers, and each number has its own direction and privilege rule. Illegal accesses raise a one-cycle violation flag and change nothing.

A build-time parameter selects one of two address maps. The split map (the default) gives every half one read-only number that user code may use and one write-only number that only privileged code may use. The legacy map gives every half one privileged read/write number and one read-only number open to user code. Register numbers that neither map uses get a zero read and no violation, so other register blocks can sit on the same port.

Top module: `tbase_unit`

## Requirements
- R1: With `tickEn` high and no successful write in that cycle, the 64-bit count rises by exactly one at the clock edge. When the low half is all ones, it wraps to zero and the high half rises by one at the same edge. With `tickEn` low and no write, the count holds.
- R2: With `LEGACY_MAP` = 0, a read at 0x10C returns the low half and a read at 0x10D returns the high half, in either privilege mode. The value appears on `sprRData` in the cycle after the strobe and is the count as it stood in the strobe cycle.
- R3: With `LEGACY_MAP` = 0, a privileged write at 0x11C loads the low half and a privileged write at 0x11D loads the high half. In that cycle the other half keeps its value and no increment is applied, even with `tickEn` high.
- R4: With `LEGACY_MAP` = 0, three kinds of access raise `accessViol` for one cycle in the cycle after the strobe, return zero read data and leave the count as R1 alone would set it: a read at 0x11C or 0x11D, a write at 0x10C or 0x10D, and a write at 0x11C or 0x11D with `sprPriv` low.
- R5: With `LEGACY_MAP` = 1, the high half is read/write at 0x3DC and the low half is read/write at 0x3DD; both numbers are privileged. The high half can also be read at 0x3CC and the low half at 0x1BE, in either mode. Reads and writes follow the timing of R2 and R3.
- R6: With `LEGACY_MAP` = 1, any access at 0x3DC or 0x3DD with `sprPriv` low is a violation, and so is any write at 0x3CC or 0x1BE. Each has the effects described in R4.
- R7: An access at a register number that the selected map does not use returns zero read data, raises no violation and leaves the count unchanged.
- R8: If `sprRead` and `sprWrite` are both high at a register number the map uses, the access is a violation with the effects described in R4.
- R9: While `rstN` is low, the count, `sprRData` and `accessViol` are all zero.
- R10: In a cycle with no strobe, the next cycle shows `sprRData` at zero and `accessViol` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | Count-advance enable for this cycle |
| sprAddr | input | ADDR_W | Special-register number |
| sprRead | input | 1 | Read strobe |
| sprWrite | input | 1 | Write strobe |
| sprPriv | input | 1 | High when the access is privileged |
| sprWData | input | HALF_W | Write data for one half |
| sprRData | output | HALF_W | Registered read data, zero when nothing is read |
| accessViol | output | 1 | One-cycle flag for an illegal access |

## Verification
Two functions can land in the same cycle: a software write to one half and a tick-driven increment. The bench drives a write with `tickEn` high, both when the low half is in the middle of its range and when it is all ones, so the carry would otherwise reach the high half. Reads that follow must show the written half exactly as written and the other half unchanged, with no increment. A scoreboard models both maps side by side and compares every cycle's read data and violation flag against that model.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  // Per-number attributes produced by the address decode.
  typedef struct packed {
    logic hit;      // number belongs to this block
    logic upper;    // selects the high half
    logic rdOk;     // reads permitted
    logic wrOk;     // writes permitted
    logic rdPriv;   // read needs privilege
    logic wrPriv;   // write needs privilege
  } tbAttr_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic readLo;
    logic readHi;
    logic viol;
  } tbStrobe_t;

endpackage

// File: rtl/tbase_ctrl.sv
module tbase_ctrl
  import tbase_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter bit LEGACY_MAP = 1'b0
) (
  input  logic [ADDR_W-1:0] sprAddr,
  input  logic              sprRead,
  input  logic              sprWrite,
  input  logic              sprPriv,
  output tbStrobe_t         strobe
);

  tbAttr_t attr;

  generate
    if (LEGACY_MAP) begin : g_legacy
      localparam logic [ADDR_W-1:0] HiRw = ADDR_W'(10'h3DC);
      localparam logic [ADDR_W-1:0] HiRo = ADDR_W'(10'h3CC);
      localparam logic [ADDR_W-1:0] LoRw = ADDR_W'(10'h3DD);
      localparam logic [ADDR_W-1:0] LoRo = ADDR_W'(10'h1BE);

      always_comb begin
        attr = '0;
        case (sprAddr)
          HiRw: begin
            attr.hit = 1'b1; attr.upper = 1'b1;
            attr.rdOk = 1'b1; attr.wrOk = 1'b1;
            attr.rdPriv = 1'b1; attr.wrPriv = 1'b1;
          end
          HiRo: begin
            attr.hit = 1'b1; attr.upper = 1'b1; attr.rdOk = 1'b1;
          end
          LoRw: begin
            attr.hit = 1'b1;
            attr.rdOk = 1'b1; attr.wrOk = 1'b1;
            attr.rdPriv = 1'b1; attr.wrPriv = 1'b1;
          end
          LoRo: begin
            attr.hit = 1'b1; attr.rdOk = 1'b1;
          end
          default: attr = '0;
        endcase
      end
    end else begin : g_split
      localparam logic [ADDR_W-1:0] LoRd = ADDR_W'(10'h10C);
      localparam logic [ADDR_W-1:0] HiRd = ADDR_W'(10'h10D);
      localparam logic [ADDR_W-1:0] LoWr = ADDR_W'(10'h11C);
      localparam logic [ADDR_W-1:0] HiWr = ADDR_W'(10'h11D);

      always_comb begin
        attr = '0;
        case (sprAddr)
          LoRd: begin
            attr.hit = 1'b1; attr.rdOk = 1'b1;
          end
          HiRd: begin
            attr.hit = 1'b1; attr.upper = 1'b1; attr.rdOk = 1'b1;
          end
          LoWr: begin
            attr.hit = 1'b1; attr.wrOk = 1'b1; attr.wrPriv = 1'b1;
          end
          HiWr: begin
            attr.hit = 1'b1; attr.upper = 1'b1;
            attr.wrOk = 1'b1; attr.wrPriv = 1'b1;
          end
          default: attr = '0;
        endcase
      end
    end
  endgenerate

  logic rdDenied;
  logic wrDenied;

  assign rdDenied = !attr.rdOk || (attr.rdPriv && !sprPriv);
  assign wrDenied = !attr.wrOk || (attr.wrPriv && !sprPriv);

  always_comb begin
    strobe = '0;
    if (attr.hit && (sprRead || sprWrite)) begin
      if (sprRead && sprWrite) begin
        strobe.viol = 1'b1;
      end else if (sprRead) begin
        if (rdDenied)         strobe.viol   = 1'b1;
        else if (attr.upper)  strobe.readHi = 1'b1;
        else                  strobe.readLo = 1'b1;
      end else begin
        if (wrDenied)         strobe.viol   = 1'b1;
        else if (attr.upper)  strobe.loadHi = 1'b1;
        else                  strobe.loadLo = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tbase_dp.sv
module tbase_dp
  import tbase_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  tbStrobe_t         strobe,
  input  logic [HALF_W-1:0] wData,
  output logic [HALF_W-1:0] rData,
  output logic              viol,
  output logic [HALF_W-1:0] cntLo,
  output logic [HALF_W-1:0] cntHi
);

  logic [HALF_W-1:0] loInc;
  logic              loCarry;

  assign loInc   = cntLo + 1'b1;
  assign loCarry = &cntLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo <= '0;
      cntHi <= '0;
    end else if (strobe.loadLo) begin
      cntLo <= wData;
    end else if (strobe.loadHi) begin
      cntHi <= wData;
    end else if (tickEn) begin
      cntLo <= loInc;
      if (loCarry) cntHi <= cntHi + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rData <= '0;
      viol  <= 1'b0;
    end else begin
      viol <= strobe.viol;
      if (strobe.readLo)      rData <= cntLo;
      else if (strobe.readHi) rData <= cntHi;
      else                    rData <= '0;
    end
  end

endmodule

// File: rtl/tbase_unit.sv
module tbase_unit
  import tbase_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int HALF_W     = 32,
  parameter bit LEGACY_MAP = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [ADDR_W-1:0] sprAddr,
  input  logic              sprRead,
  input  logic              sprWrite,
  input  logic              sprPriv,
  input  logic [HALF_W-1:0] sprWData,
  output logic [HALF_W-1:0] sprRData,
  output logic              accessViol
);

  tbStrobe_t         strobe;
  logic [HALF_W-1:0] cntLo;
  logic [HALF_W-1:0] cntHi;

  tbase_ctrl #(
    .ADDR_W    (ADDR_W),
    .LEGACY_MAP(LEGACY_MAP)
  ) ctrlI (
    .sprAddr (sprAddr),
    .sprRead (sprRead),
    .sprWrite(sprWrite),
    .sprPriv (sprPriv),
    .strobe  (strobe)
  );

  tbase_dp #(
    .HALF_W(HALF_W)
  ) dpI (
    .clk   (clk),
    .rstN  (rstN),
    .tickEn(tickEn),
    .strobe(strobe),
    .wData (sprWData),
    .rData (sprRData),
    .viol  (accessViol),
    .cntLo (cntLo),
    .cntHi (cntHi)
  );

endmodule

// File: rtl/tbase_chk.sv
module tbase_chk #(
  parameter int ADDR_W     = 10,
  parameter int HALF_W     = 32,
  parameter bit LEGACY_MAP = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [ADDR_W-1:0] sprAddr,
  input logic              sprRead,
  input logic              sprWrite,
  input logic              sprPriv,
  input logic [HALF_W-1:0] sprRData,
  input logic              accessViol,
  input logic [HALF_W-1:0] cntLo,
  input logic [HALF_W-1:0] cntHi
);

  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0] fullCnt;
  logic             privOnlyWr;
  logic             mapped;

  assign fullCnt = {cntHi, cntLo};

  assign privOnlyWr = LEGACY_MAP ?
      (sprAddr == ADDR_W'(10'h3DC) || sprAddr == ADDR_W'(10'h3DD)) :
      (sprAddr == ADDR_W'(10'h11C) || sprAddr == ADDR_W'(10'h11D));

  assign mapped = LEGACY_MAP ?
      (sprAddr == ADDR_W'(10'h3DC) || sprAddr == ADDR_W'(10'h3DD) ||
       sprAddr == ADDR_W'(10'h3CC) || sprAddr == ADDR_W'(10'h1BE)) :
      (sprAddr == ADDR_W'(10'h10C) || sprAddr == ADDR_W'(10'h10D) ||
       sprAddr == ADDR_W'(10'h11C) || sprAddr == ADDR_W'(10'h11D));

  // R1
  cnt_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !sprWrite) |=> fullCnt == $past(fullCnt) + CNT_W'(1));

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !sprWrite) |=> $stable(fullCnt));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sprRead && !sprWrite) |=> (!accessViol && sprRData == '0));

  // R4
  viol_zero_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessViol |-> sprRData == '0);

  // R6
  user_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sprWrite && !sprPriv && privOnlyWr) |=> accessViol);

  // R7
  unmapped_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sprRead || sprWrite) && !mapped) |=> (!accessViol && sprRData == '0));

  // R8
  dual_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sprRead && sprWrite && mapped) |=> accessViol);

endmodule

bind tbase_unit tbase_chk #(
  .ADDR_W    (ADDR_W),
  .HALF_W    (HALF_W),
  .LEGACY_MAP(LEGACY_MAP)
) chkI (.*);

// File: tb/tb_tbase_unit.sv
`timescale 1ns/100ps
module tb_tbase_unit;

  localparam int K_NONE = 0, K_RLO = 1, K_RHI = 2, K_WLO = 3, K_WHI = 4, K_VIOL = 5;

  typedef struct {
    logic [31:0] rdA;
    logic        violA;
    logic [31:0] rdB;
    logic        violB;
    string       tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0;
  logic [9:0]  sprAddr = '0;
  logic        sprRead = 1'b0;
  logic        sprWrite = 1'b0;
  logic        sprPriv = 1'b0;
  logic [31:0] sprWData = '0;
  logic [31:0] rdA, rdB;
  logic        violA, violB;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  expItem_t expQ[$];
  logic [63:0] mdlA = '0;
  logic [63:0] mdlB = '0;

  always #2.5 clk = ~clk;

  tbase_unit #(.LEGACY_MAP(1'b0)) dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sprAddr(sprAddr),
    .sprRead(sprRead), .sprWrite(sprWrite), .sprPriv(sprPriv),
    .sprWData(sprWData), .sprRData(rdA), .accessViol(violA));

  tbase_unit #(.LEGACY_MAP(1'b1)) dutLeg (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .sprAddr(sprAddr),
    .sprRead(sprRead), .sprWrite(sprWrite), .sprPriv(sprPriv),
    .sprWData(sprWData), .sprRData(rdB), .accessViol(violB));

  // Access classification taken from R2..R8.
  function automatic int classify(bit leg, logic [9:0] a, logic rd, logic wr, logic pv);
    bit hit, up, rok, wok, rpv, wpv;
    hit = 0; up = 0; rok = 0; wok = 0; rpv = 0; wpv = 0;
    if (!leg) begin
      case (a)
        10'h10C: begin hit = 1; rok = 1; end
        10'h10D: begin hit = 1; up = 1; rok = 1; end
        10'h11C: begin hit = 1; wok = 1; wpv = 1; end
        10'h11D: begin hit = 1; up = 1; wok = 1; wpv = 1; end
        default: ;
      endcase
    end else begin
      case (a)
        10'h3DC: begin hit = 1; up = 1; rok = 1; wok = 1; rpv = 1; wpv = 1; end
        10'h3CC: begin hit = 1; up = 1; rok = 1; end
        10'h3DD: begin hit = 1; rok = 1; wok = 1; rpv = 1; wpv = 1; end
        10'h1BE: begin hit = 1; rok = 1; end
        default: ;
      endcase
    end
    if (!hit || (!rd && !wr)) return K_NONE;
    if (rd && wr) return K_VIOL;
    if (rd) begin
      if (!rok || (rpv && !pv)) return K_VIOL;
      return up ? K_RHI : K_RLO;
    end
    if (!wok || (wpv && !pv)) return K_VIOL;
    return up ? K_WHI : K_WLO;
  endfunction

  function automatic logic [63:0] nextCnt(logic [63:0] c, int k, logic [31:0] wd, logic te);
    if (k == K_WLO) return {c[63:32], wd};
    if (k == K_WHI) return {wd, c[31:0]};
    if (te) return c + 64'd1;
    return c;
  endfunction

  function automatic logic [31:0] expRd(logic [63:0] c, int k);
    if (k == K_RLO) return c[31:0];
    if (k == K_RHI) return c[63:32];
    return 32'd0;
  endfunction

  // Driver: called at a falling edge; drives one cycle and queues its expectation.
  task automatic step(input logic [9:0] a, input logic rd, input logic wr,
                      input logic pv, input logic [31:0] wd, input logic te,
                      input string tag);
    expItem_t it;
    int kA, kB;
    sprAddr = a; sprRead = rd; sprWrite = wr; sprPriv = pv;
    sprWData = wd; tickEn = te;
    kA = classify(1'b0, a, rd, wr, pv);
    kB = classify(1'b1, a, rd, wr, pv);
    it.rdA = expRd(mdlA, kA); it.violA = (kA == K_VIOL);
    it.rdB = expRd(mdlB, kB); it.violB = (kB == K_VIOL);
    it.tag = tag;
    mdlA = nextCnt(mdlA, kA, wd, te);
    mdlB = nextCnt(mdlB, kB, wd, te);
    expQ.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: compares each cycle's outputs just after the edge.
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (rdA !== e.rdA || violA !== e.violA || rdB !== e.rdB || violB !== e.violB) begin
        errors++;
        $display("FAIL %s: split rd=%h viol=%b (exp %h %b), legacy rd=%h viol=%b (exp %h %b)",
                 e.tag, rdA, violA, e.rdA, e.violA, rdB, violB, e.rdB, e.violB);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (rdA !== 32'd0 || violA !== 1'b0 || rdB !== 32'd0 || violB !== 1'b0) begin
      errors++;
      $display("FAIL R9: rd=%h/%h viol=%b/%b (exp 0/0 0/0)", rdA, rdB, violA, violB);
    end
    rstN = 1'b1;

    // R9: count is zero after reset
    step(10'h10C, 1, 0, 0, 0, 0, "R9");
    step(10'h1BE, 1, 0, 0, 0, 0, "R9");

    // R3 / R5: load both halves in each map
    step(10'h11C, 0, 1, 1, 32'hFFFF_FFFE, 0, "R3");
    step(10'h3DD, 0, 1, 1, 32'hFFFF_FFFE, 0, "R5");
    step(10'h11D, 0, 1, 1, 32'h0000_0007, 0, "R3");
    step(10'h3DC, 0, 1, 1, 32'h0000_0007, 0, "R5");

    // R1 / R10: idle ticks across the low-half wrap
    for (int i = 0; i < 3; i++) step(10'h000, 0, 0, 0, 0, 1, "R10");

    // R2 / R5: reads in user mode
    step(10'h10C, 1, 0, 0, 0, 0, "R2");
    step(10'h10D, 1, 0, 0, 0, 0, "R2");
    step(10'h1BE, 1, 0, 0, 0, 0, "R5");
    step(10'h3CC, 1, 0, 0, 0, 0, "R5");
    step(10'h3DC, 1, 0, 1, 0, 0, "R5");

    // R4: split-map violations
    step(10'h10C, 0, 1, 1, 32'hDEAD_BEEF, 0, "R4");
    step(10'h11C, 1, 0, 1, 0, 0, "R4");
    step(10'h11D, 0, 1, 0, 32'hDEAD_BEEF, 0, "R4");
    // R6: legacy-map violations
    step(10'h3CC, 0, 1, 1, 32'hCAFE_0000, 0, "R6");
    step(10'h1BE, 0, 1, 1, 32'hCAFE_0000, 0, "R6");
    step(10'h3DC, 1, 0, 0, 0, 0, "R6");
    step(10'h3DD, 0, 1, 0, 32'hCAFE_0000, 0, "R6");
    // state untouched after violations
    step(10'h10D, 1, 0, 0, 0, 0, "R4");
    step(10'h3DC, 1, 0, 1, 0, 0, "R6");
    step(10'h3DD, 1, 0, 1, 0, 0, "R6");

    // R7: unmapped numbers
    step(10'h200, 1, 0, 1, 0, 0, "R7");
    step(10'h200, 0, 1, 1, 32'h1234_5678, 0, "R7");
    step(10'h10C, 1, 0, 0, 0, 0, "R7");

    // R8: both strobes together
    step(10'h11C, 1, 1, 1, 32'h5555_5555, 0, "R8");
    step(10'h3DD, 1, 1, 1, 32'h5555_5555, 0, "R8");
    step(10'h10C, 1, 0, 0, 0, 0, "R8");
    step(10'h1BE, 1, 0, 0, 0, 0, "R8");

    // R3: write and tick in the same cycle, incl. pending carry
    step(10'h11C, 0, 1, 1, 32'hFFFF_FFFF, 1, "R3");
    step(10'h3DD, 0, 1, 1, 32'hFFFF_FFFF, 1, "R3");
    step(10'h11D, 0, 1, 1, 32'h0000_00A5, 1, "R3");
    step(10'h3DC, 0, 1, 1, 32'h0000_00A5, 1, "R3");
    step(10'h10C, 1, 0, 0, 0, 0, "R3");
    step(10'h10D, 1, 0, 0, 0, 0, "R3");
    step(10'h1BE, 1, 0, 0, 0, 0, "R3");
    step(10'h3CC, 1, 0, 0, 0, 0, "R3");

    // R1: running count with interleaved reads
    for (int i = 0; i < 24; i++) begin
      case (i % 4)
        0: step(10'h10C, 1, 0, 0, 0, 1, "R1");
        1: step(10'h10D, 1, 0, 0, 0, 1, "R1");
        2: step(10'h1BE, 1, 0, 0, 0, 1, "R1");
        default: step(10'h3CC, 1, 0, 0, 0, 1, "R1");
      endcase
    end

    step(10'h000, 0, 0, 0, 0, 0, "R10");
    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule